// File: doc/BRIEF.md
# Dual 16-bit Output Compare Unit

This block holds two 16-bit compare values next to a free-running 16-bit counter and raises one compare flag per channel when the counter reaches that channel's value. The compare values are loaded over an 8-bit register bus. Each value is written as two bytes. A single holding byte, shared by every byte-split register on the bus, makes the full 16-bit update take effect in one step. The high byte is parked in the holding byte, and the low-byte write then commits both halves together.

The counter is kept outside the block. The block receives the counter value and a strobe that marks the cycles where the counter has just advanced. Equality is judged only on those cycles. A counter or compare value set by a software write therefore never raises a flag by itself. Each flag is registered, stays set until its clear input is asserted, and wins over a clear that arrives in the same cycle.

Top module: `dual_ocmp`

## Requirements
- R1: After synchronous reset both compare values, both flags and the holding byte are zero.
- R2: A bus write with address bit 0 = 1 (high byte) stores the data only in the holding byte; no compare value changes.
- R3: A bus write with address bit 0 = 0 (low byte) loads {holding byte, data} into the compare value of the channel given by address bit 1 (0 = A, 1 = B) at that clock edge.
- R4: One holding byte is shared by both channels, so a high-byte write to either channel replaces what an earlier high-byte write left there, and a low-byte write with no fresh high-byte write reuses the stale holding byte.
- R5: A channel's flag is set only when the advance strobe is high and the counter value equals that channel's compare value in the same cycle; equality without the strobe never sets it.
- R6: The flag becomes visible in the cycle after the matching cycle and then stays set until it is cleared.
- R7: Match detection uses the compare value held before a low-byte write that occurs in the same cycle.
- R8: A high clear bit for a channel clears its flag at the next edge, unless a match for that channel occurs in the same cycle, in which case the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 2 | Bit 0: byte select (1 = high), bit 1: channel (0 = A, 1 = B) |
| bus_wdata | input | 8 | Write data byte |
| cnt_val | input | 16 | Current counter value |
| cnt_adv | input | 1 | High when the counter has just advanced |
| flag_clr | input | 2 | Per-channel flag clear (bit 0 = A, bit 1 = B) |
| ocr_val | output | 32 | Compare values, A in bits 15:0, B in bits 31:16 |
| cmp_flag | output | 2 | Per-channel compare flags (bit 0 = A, bit 1 = B) |

## Verification
The case that needs care is a match and a flag clear landing in the same cycle, together with a match and a low-byte write landing in the same cycle. The bench drives the counter to the compare value with the advance strobe while the clear bit is high, and it expects the flag to be set. It also writes a new low byte while the counter advances onto the old value or onto the new value, and it expects a match only against the old value. A random phase keeps counter and compare values in a narrow range so that all of these collisions recur, and a behavioural model checks every output on every clock.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int unsigned OC_BYTE_W = 8;
    localparam int unsigned OC_NCH    = 2;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;

    function automatic byte_sel_e byte_of(input logic a0);
        return a0 ? BYTE_HI : BYTE_LO;
    endfunction

endpackage

// File: rtl/ocmp_temp.sv
module ocmp_temp
    import ocmp_pkg::*;
#(
    parameter int unsigned BYTE_W = OC_BYTE_W,
    parameter int unsigned NCH    = OC_NCH,
    parameter int unsigned AW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] temp_q,
    output logic [NCH-1:0]    lo_wr
);

    byte_sel_e         sel;
    logic [AW-2:0]     ch;

    assign sel = byte_of(bus_addr[0]);
    assign ch  = bus_addr[AW-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (bus_we && sel == BYTE_HI) begin
            temp_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign lo_wr[g] = bus_we && (sel == BYTE_LO) && (int'(ch) == g);
    end

    AST_TEMP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[0]) |=> temp_q == $past(bus_wdata)); // R4

    AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr[0]) |=> $stable(temp_q)); // R4

endmodule

// File: rtl/ocmp_chan.sv
module ocmp_chan
    import ocmp_pkg::*;
#(
    parameter int unsigned BYTE_W = OC_BYTE_W,
    localparam int unsigned CW    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] temp_in,
    input  logic [CW-1:0]     cnt_val,
    input  logic              cnt_adv,
    input  logic              clr,
    output logic [CW-1:0]     ocr_q,
    output logic              flag_q
);

    logic match;

    assign match = cnt_adv && (cnt_val == ocr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ocr_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (lo_wr) begin
                ocr_q <= {temp_in, wdata};
            end
            if (match) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> ocr_q == {$past(temp_in), $past(wdata)}); // R3

    AST_OCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lo_wr |=> $stable(ocr_q)); // R2

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(cnt_adv) && $past(cnt_val) == $past(ocr_q))); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_adv && cnt_val == ocr_q && clr) |=> flag_q); // R8

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(cnt_adv && cnt_val == ocr_q)) |=> !flag_q); // R8

endmodule

// File: rtl/dual_ocmp.sv
module dual_ocmp
    import ocmp_pkg::*;
#(
    parameter int unsigned BYTE_W = OC_BYTE_W,
    parameter int unsigned NCH    = OC_NCH,
    localparam int unsigned CW    = 2 * BYTE_W,
    localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW    = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CW-1:0]     cnt_val,
    input  logic              cnt_adv,
    input  logic [NCH-1:0]    flag_clr,
    output logic [NCH*CW-1:0] ocr_val,
    output logic [NCH-1:0]    cmp_flag
);

    logic [BYTE_W-1:0] temp_q;
    logic [NCH-1:0]    lo_wr;

    ocmp_temp #(.BYTE_W(BYTE_W), .NCH(NCH), .AW(AW)) u_temp (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .temp_q    (temp_q),
        .lo_wr     (lo_wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ocmp_chan #(.BYTE_W(BYTE_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .lo_wr   (lo_wr[c]),
            .wdata   (bus_wdata),
            .temp_in (temp_q),
            .cnt_val (cnt_val),
            .cnt_adv (cnt_adv),
            .clr     (flag_clr[c]),
            .ocr_q   (ocr_val[c*CW +: CW]),
            .flag_q  (cmp_flag[c])
        );
    end

    AST_HI_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[0]) |=> $stable(ocr_val)); // R2

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (ocr_val == '0 && cmp_flag == '0)); // R1

endmodule

// File: tb/dual_ocmp_test.sv
`timescale 1ns/1ps
module dual_ocmp_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [15:0] cnt_val;
    logic        cnt_adv;
    logic [1:0]  flag_clr;
    logic [31:0] ocr_val;
    logic [1:0]  cmp_flag;

    always #5 clk = ~clk;

    dual_ocmp uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_val(cnt_val), .cnt_adv(cnt_adv),
        .flag_clr(flag_clr), .ocr_val(ocr_val), .cmp_flag(cmp_flag)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference
    int m_ocr  [2];
    int m_flag [2];
    int m_temp;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ocr[0] = 0; m_ocr[1] = 0; m_flag[0] = 0; m_flag[1] = 0; m_temp = 0;
    endtask

    task automatic compare_all();
        for (int c = 0; c < 2; c++) begin
            check(int'(ocr_val[c*16 +: 16]) == m_ocr[c], "R2/R3 compare value",
                  int'(ocr_val[c*16 +: 16]), m_ocr[c]);
            check(int'(cmp_flag[c]) == m_flag[c], "R5/R6 flag",
                  int'(cmp_flag[c]), m_flag[c]);
        end
    endtask

    // drive one cycle, clock it, update the model, compare
    task automatic step(input bit we, input int addr, input int data,
                        input int cnt, input bit adv, input int clr);
        bus_we = we; bus_addr = 2'(addr); bus_wdata = 8'(data);
        cnt_val = 16'(cnt); cnt_adv = adv; flag_clr = 2'(clr);
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            if (adv && (cnt & 16'hFFFF) == m_ocr[c]) m_flag[c] = 1;
            else if (clr[c]) m_flag[c] = 0;
        end
        if (we) begin
            if (addr[0]) m_temp = data & 8'hFF;
            else m_ocr[addr[1]] = (m_temp << 8) | (data & 8'hFF);
        end
        #1;
        compare_all();
        bus_we = 0; cnt_adv = 0; flag_clr = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        cnt_val = 0; cnt_adv = 0; flag_clr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1 reset state
        check(ocr_val == 32'h0, "R1 compare values", int'(ocr_val), 0);
        check(cmp_flag == 2'b00, "R1 flags", int'(cmp_flag), 0);

        // R2 high byte alone changes nothing visible
        step(1, 1, 8'h12, 16'h0100, 0, 0);
        check(ocr_val[15:0] == 16'h0000, "R2 high write parked", int'(ocr_val[15:0]), 0);
        // R3 low byte commits both halves
        step(1, 0, 8'h34, 16'h0100, 0, 0);
        check(ocr_val[15:0] == 16'h1234, "R3 low write commit", int'(ocr_val[15:0]), 16'h1234);

        // R4 shared holding byte
        step(1, 1, 8'hAA, 16'h0100, 0, 0);
        step(1, 3, 8'hBB, 16'h0100, 0, 0);
        step(1, 0, 8'h01, 16'h0100, 0, 0);
        check(ocr_val[15:0] == 16'hBB01, "R4 shared temp A", int'(ocr_val[15:0]), 16'hBB01);
        step(1, 2, 8'h02, 16'h0100, 0, 0);
        check(ocr_val[31:16] == 16'hBB02, "R4 stale temp B", int'(ocr_val[31:16]), 16'hBB02);

        // R5 equality without advance
        step(0, 0, 0, 16'hBB01, 0, 0);
        step(0, 0, 0, 16'hBB01, 0, 0);
        check(cmp_flag[0] == 1'b0, "R5 no match without advance", int'(cmp_flag[0]), 0);

        // R6 flag appears the cycle after the match cycle
        step(0, 0, 0, 16'hBB00, 1, 0);
        check(cmp_flag[0] == 1'b0, "R6 before match", int'(cmp_flag[0]), 0);
        step(0, 0, 0, 16'hBB01, 1, 0);
        check(cmp_flag[0] == 1'b1, "R6 after match", int'(cmp_flag[0]), 1);
        step(0, 0, 0, 16'hBB02, 1, 0);
        check(cmp_flag == 2'b11, "R6 B matched, A sticky", int'(cmp_flag), 3);

        // R8 clear, then set wins over clear
        step(0, 0, 0, 16'hBB03, 1, 1);
        check(cmp_flag[0] == 1'b0, "R8 clear", int'(cmp_flag[0]), 0);
        step(0, 0, 0, 16'hBB01, 1, 1);
        check(cmp_flag[0] == 1'b1, "R8 set wins", int'(cmp_flag[0]), 1);
        step(0, 0, 0, 16'h0000, 0, 3);
        check(cmp_flag == 2'b00, "R8 clear both", int'(cmp_flag), 0);

        // R7 match uses pre-write value
        step(1, 0, 8'h55, 16'hBB55, 1, 0);
        check(cmp_flag[0] == 1'b0, "R7 new value not yet compared", int'(cmp_flag[0]), 0);
        step(1, 0, 8'h66, 16'hBB55, 1, 0);
        check(cmp_flag[0] == 1'b1, "R7 old value compared", int'(cmp_flag[0]), 1);
        check(ocr_val[15:0] == 16'hBB66, "R7 write still lands", int'(ocr_val[15:0]), 16'hBB66);

        // random phase: narrow value range so collisions recur
        step(1, 1, 0, 0, 0, 3);
        step(1, 0, 8'h05, 0, 0, 0);
        step(1, 2, 8'h09, 0, 0, 0);
        cnt = 0;
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit we, adv;
            r   = int'($urandom_range(0, 99));
            we  = (r < 20);
            adv = ($urandom_range(0, 2) != 0);
            if (adv) cnt = (cnt + 1) & 16'h1F;
            else if (r > 90) cnt = int'($urandom_range(0, 31));
            step(we, int'($urandom_range(0, 3)),
                 (r < 5) ? 8'h01 : (r < 12 ? 8'h00 : int'($urandom_range(0, 31))),
                 cnt, adv, int'($urandom_range(0, 3)) & (($urandom_range(0, 3) == 0) ? 3 : 0));
        end

        // R1 reset mid-run
        rst = 1;
        @(posedge clk);
        #1;
        rst = 0;
        model_reset();
        check(ocr_val == 32'h0 && cmp_flag == 2'b00, "R1 reset after activity",
              int'(ocr_val), 0);
        step(1, 0, 8'h77, 0, 0, 0);
        check(ocr_val[15:0] == 16'h0077, "R1 holding byte cleared", int'(ocr_val[15:0]), 16'h0077);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule